// File: doc/BRIEF.md
# Flash Reset and Bootstrap Responder

This block sits in front of a flash memory module. It decides at reset whether the module comes up stopped or active, and it answers bus requests once reset has ended. While reset is held, it samples three values every cycle:

- a non-volatile stop shadow bit,
- a non-volatile boot shadow bit,
- one external data pin.

The module comes up active only when the stop shadow bit is programmed to 0 and the pin is pulled high. Erased shadow bits read as 1, so a blank part always comes up stopped. This leaves the address space free for an external device until software clears the stop control bit.

After reset the block claims three kinds of request:

- Program-space reads of the four bootstrap vector words at byte addresses 0, 2, 4 and 6. These are answered only when the boot flag was captured as 1 and the module is not stopped.
- Accesses inside the array window, whose base is held in a writable base register.
- Accesses to a small register window. This window stays reachable even while the module is stopped.

Array contents come from a fixed lookup. The shadow bits and bootstrap words arrive as plain inputs. Every claimed request is acknowledged one cycle later, together with its read data.

Top module: `flash_boot_responder`

## Requirements
- R1: While rst_n is low, the stop bit is loaded each cycle with (stop shadow OR NOT data pin). stop_o therefore comes out of reset as 1 unless the stop shadow is 0 and the pin is 1.
- R2: boot_o holds the boot shadow value captured during reset. It cannot be changed by any write, and it reads back as bit 1 of the control register.
- R3: While stop_o is 1, neither the bootstrap range nor the array window is acknowledged. The register window still answers.
- R4: A program-space read with boot_o=1 and stop_o=0 at byte address 0, 2, 4 or 6 is acknowledged. The returned word is boot_words_i[16*n +: 16], where n is address bits [2:1].
- R5: With boot_o=0, program-space reads of addresses 0 to 6 are not acknowledged unless the array window covers them. Data-space reads of those addresses are never answered as bootstrap.
- R6: An access whose address bits [23:14] equal the base register is an array hit, in either space, when stop_o=0. A read of an array hit returns address bits [16:1] XOR 16'h5A3C. An array write is acknowledged and has no effect.
- R7: The register window consists of data-space accesses whose address bits [23:4] match those of REG_BASE (default 24'hFFF800). The register at word offset 0 is control: bit 0 is stop and is writable, bit 1 is boot and is read-only. Word offset 1 is the base register, held in bits [9:0]. Word offsets 4 to 7 are bootstrap words 0 to 3.
- R8: Writes to the bootstrap word registers are acknowledged, but the value read back does not change.
- R9: When more than one window matches, the register window wins over the bootstrap range, and the bootstrap range wins over the array window.
- R10: ack_o rises exactly one cycle after a claimed request and is low otherwise. rdata_o carries read data with the acknowledge and is 0 for writes and unclaimed cycles.
- R11: Reset loads the base register with BASE_RST (default 10'h004, placing the array at 24'h010000).
- R12: Requests with address bit 0 set are never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; shadow bits and pin are sampled while it is low |
| shadow_stop_i | input | 1 | Non-volatile stop shadow bit (erased = 1) |
| shadow_boot_i | input | 1 | Non-volatile boot shadow bit (erased = 1) |
| data_pin_i | input | 1 | External data pin sampled during reset |
| boot_words_i | input | 64 | Bootstrap words 0..3, word n in bits [16n+15:16n] |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_prog_i | input | 1 | 1 = program-space access, 0 = data space |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Request claimed (one cycle after the request) |
| rdata_o | output | 16 | Read data, valid with ack_o |
| stop_o | output | 1 | Module stop control bit |
| boot_o | output | 1 | Boot flag captured at reset |

## Verification
A wrong stop bit is visible on stop_o right after reset is released. It shows up again one cycle after the first bootstrap or array request, as an acknowledge that is missing or should not be there. A corrupted base register moves the array window, so array reads are acknowledged at the wrong addresses. It also returns the wrong value through the base register read on the next cycle. A wrong bootstrap word selection appears in rdata_o one cycle after the fetch, which is why all four vector addresses are read back in order.

// File: rtl/flash_boot_pkg.sv
// Shared types and constants for the flash reset and bootstrap responder.
// Assumes 16-bit data words and a 16-byte register window.
package flash_boot_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_REG  = 2'd1,
        SEL_BOOT = 2'd2,
        SEL_ARR  = 2'd3
    } sel_e;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned NUM_BOOTW = 4;
    localparam logic [2:0]  OFS_CTRL  = 3'd0;
    localparam logic [2:0]  OFS_BASE  = 3'd1;
    localparam logic [15:0] ARR_SEED  = 16'h5A3C;
endpackage

// File: rtl/flash_reset_ctl.sv
// Holds the stop bit, boot flag and array base register.
// During reset it samples the shadow bits and the data pin; afterwards only
// register writes decoded by the parent can change stop and base.
// Assumes BW <= 16.
module flash_reset_ctl #(
    parameter int unsigned BW = 10,
    parameter logic [BW-1:0] BASE_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shadow_stop_i,
    input  logic          shadow_boot_i,
    input  logic          data_pin_i,
    input  logic          ctrl_we_i,
    input  logic          base_we_i,
    input  logic [15:0]   wdata_i,
    output logic          stop_o,
    output logic          boot_o,
    output logic [BW-1:0] base_o
);
    logic          stop_q;
    logic          boot_q;
    logic [BW-1:0] base_q;

    // Reset-time sampling of shadow state, then software updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= shadow_stop_i | ~data_pin_i;
            boot_q <= shadow_boot_i;
            base_q <= BASE_RST;
        end else begin
            if (ctrl_we_i) stop_q <= wdata_i[0];
            if (base_we_i) base_q <= wdata_i[BW-1:0];
        end
    end

    assign stop_o = stop_q;
    assign boot_o = boot_q;
    assign base_o = base_q;

    // R2: boot flag frozen outside reset
    a_r2_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(boot_q));
    // R7: stop changes only through a control write
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we_i |=> $stable(stop_q));
    // R11: base changes only through a base write
    a_r11_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we_i |=> $stable(base_q));
endmodule

// File: rtl/flash_addr_decode.sv
// Decodes one request into a single selected target with fixed priority:
// register window, then bootstrap range, then array window.
// Assumes a word-aligned byte address with bit 0 already removed.
module flash_addr_decode
    import flash_boot_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned ARR_AW = 14,
    parameter logic [AW-1:0] REG_BASE = '0,
    localparam int unsigned BW = AW - ARR_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic          write_i,
    input  logic          prog_i,
    input  logic [AW-1:1] addr_i,
    input  logic          stop_i,
    input  logic          boot_i,
    input  logic [BW-1:0] base_i,
    output sel_e          sel_o,
    output logic [2:0]    reg_ofs_o
);
    logic reg_hit, boot_hit, arr_hit;

    // Window matches for each target.
    always_comb begin
        reg_hit  = valid_i & ~prog_i & (addr_i[AW-1:4] == REG_BASE[AW-1:4]);
        boot_hit = valid_i & prog_i & ~write_i & boot_i & ~stop_i
                   & (addr_i[AW-1:3] == '0);
        arr_hit  = valid_i & ~stop_i & (addr_i[AW-1:ARR_AW] == base_i);
    end

    // Priority selection of the claiming target.
    always_comb begin
        if (reg_hit)       sel_o = SEL_REG;
        else if (boot_hit) sel_o = SEL_BOOT;
        else if (arr_hit)  sel_o = SEL_ARR;
        else               sel_o = SEL_NONE;
    end

    assign reg_ofs_o = addr_i[3:1];

    // R3: a stopped module claims only registers
    a_r3_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> (sel_o == SEL_NONE || sel_o == SEL_REG));
    // R5: bootstrap selected only with boot flag and program-space read
    a_r5_boot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == SEL_BOOT) |-> (boot_i && prog_i && !write_i));
    // R9: register window always wins when it matches
    a_r9_reg_first: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> (sel_o == SEL_REG));
endmodule

// File: rtl/flash_read_mux.sv
// Forms read data for the selected target and registers the acknowledge
// and data one cycle after the request. Writes return zero data.
// Assumes NUM_BOOTW words of WORD_W bits packed in boot_words_i.
module flash_read_mux
    import flash_boot_pkg::*;
#(
    parameter int unsigned BW = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  sel_e                          sel_i,
    input  logic                          write_i,
    input  logic [2:0]                    reg_ofs_i,
    input  logic [16:1]                   arr_word_i,
    input  logic                          stop_i,
    input  logic                          boot_i,
    input  logic [BW-1:0]                 base_i,
    input  logic [NUM_BOOTW*WORD_W-1:0]   boot_words_i,
    output logic                          ack_o,
    output logic [WORD_W-1:0]             rdata_o
);
    logic [WORD_W-1:0] bw_arr [NUM_BOOTW];
    logic [WORD_W-1:0] rd_d;
    logic              ack_q;
    logic [WORD_W-1:0] rdata_q;

    // Unpack bootstrap words.
    for (genvar g = 0; g < NUM_BOOTW; g++) begin : g_bw
        assign bw_arr[g] = boot_words_i[g*WORD_W +: WORD_W];
    end

    // Read data for the selected target.
    always_comb begin
        rd_d = '0;
        if (!write_i) begin
            unique case (sel_i)
                SEL_REG: begin
                    if (reg_ofs_i[2])               rd_d = bw_arr[reg_ofs_i[1:0]];
                    else if (reg_ofs_i == OFS_CTRL) rd_d = {14'd0, boot_i, stop_i};
                    else if (reg_ofs_i == OFS_BASE) rd_d = WORD_W'(base_i);
                    else                            rd_d = '0;
                end
                SEL_BOOT: rd_d = bw_arr[arr_word_i[2:1]];
                SEL_ARR:  rd_d = arr_word_i ^ ARR_SEED;
                default:  rd_d = '0;
            endcase
        end
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= (sel_i != SEL_NONE);
            rdata_q <= rd_d;
        end
    end

    assign ack_o   = ack_q;
    assign rdata_o = rdata_q;

    // R10: claimed request acknowledged on the next cycle
    a_r10_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != SEL_NONE) |=> ack_q);
    // R10: no claim, no acknowledge and zero data
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_NONE) |=> (!ack_q && rdata_q == '0));
endmodule

// File: rtl/flash_boot_responder.sv
// Top of the flash reset and bootstrap responder. Ties reset-time state,
// address decode and the response register together, and derives the
// register write strobes. Odd byte addresses are never claimed.
module flash_boot_responder
    import flash_boot_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned ARR_AW = 14,
    parameter logic [AW-1:0] REG_BASE = 24'hFFF800,
    parameter logic [AW-ARR_AW-1:0] BASE_RST = 10'h004
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shadow_stop_i,
    input  logic                        shadow_boot_i,
    input  logic                        data_pin_i,
    input  logic [NUM_BOOTW*WORD_W-1:0] boot_words_i,
    input  logic                        req_valid_i,
    input  logic                        req_write_i,
    input  logic                        req_prog_i,
    input  logic [AW-1:0]               req_addr_i,
    input  logic [WORD_W-1:0]           req_wdata_i,
    output logic                        ack_o,
    output logic [WORD_W-1:0]           rdata_o,
    output logic                        stop_o,
    output logic                        boot_o
);
    localparam int unsigned BW = AW - ARR_AW;

    logic          stop, boot;
    logic [BW-1:0] base;
    sel_e          sel;
    logic [2:0]    reg_ofs;
    logic          valid_al, ctrl_we, base_we;

    // Only word-aligned requests take part in decode.
    assign valid_al = req_valid_i & ~req_addr_i[0];

    // Register write strobes.
    always_comb begin
        ctrl_we = (sel == SEL_REG) & req_write_i & (reg_ofs == OFS_CTRL);
        base_we = (sel == SEL_REG) & req_write_i & (reg_ofs == OFS_BASE);
    end

    flash_reset_ctl #(.BW(BW), .BASE_RST(BASE_RST)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .shadow_stop_i(shadow_stop_i), .shadow_boot_i(shadow_boot_i),
        .data_pin_i(data_pin_i), .ctrl_we_i(ctrl_we), .base_we_i(base_we),
        .wdata_i(req_wdata_i), .stop_o(stop), .boot_o(boot), .base_o(base)
    );

    flash_addr_decode #(.AW(AW), .ARR_AW(ARR_AW), .REG_BASE(REG_BASE)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .valid_i(valid_al), .write_i(req_write_i), .prog_i(req_prog_i),
        .addr_i(req_addr_i[AW-1:1]), .stop_i(stop), .boot_i(boot),
        .base_i(base), .sel_o(sel), .reg_ofs_o(reg_ofs)
    );

    flash_read_mux #(.BW(BW)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .write_i(req_write_i),
        .reg_ofs_i(reg_ofs), .arr_word_i(req_addr_i[16:1]),
        .stop_i(stop), .boot_i(boot), .base_i(base),
        .boot_words_i(boot_words_i), .ack_o(ack_o), .rdata_o(rdata_o)
    );

    assign stop_o = stop;
    assign boot_o = boot;

    // R12: odd addresses never claimed
    a_r12_odd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_addr_i[0]) |-> (sel == SEL_NONE));
    // R1: first cycle after reset shows the sampled stop decision
    a_r1_stop_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stop == ($past(shadow_stop_i) | ~$past(data_pin_i))));
endmodule

// File: tb/sim_flash_boot_responder.sv
module sim_flash_boot_responder;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] REG_BASE = 24'hFFF800;
    localparam logic [9:0]  BASE_RST = 10'h004;
    localparam logic [63:0] BOOTW = 64'hBEEF_0246_8ACE_1357;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sh_stop = 1'b1, sh_boot = 1'b1, pin = 1'b1;
    logic v = 1'b0, w = 1'b0, p = 1'b0;
    logic [23:0] a = '0;
    logic [15:0] wd = '0;
    logic ack;
    logic [15:0] rd;
    logic stop, boot;

    int checks = 0, fails = 0;
    logic m_stop, m_boot;
    logic [9:0] m_base;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_boot_responder u0 (
        .clk(clk), .rst_n(rst_n), .shadow_stop_i(sh_stop), .shadow_boot_i(sh_boot),
        .data_pin_i(pin), .boot_words_i(BOOTW), .req_valid_i(v), .req_write_i(w),
        .req_prog_i(p), .req_addr_i(a), .req_wdata_i(wd), .ack_o(ack),
        .rdata_o(rd), .stop_o(stop), .boot_o(boot)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected target: 0 none, 1 reg, 2 boot, 3 array (R9 priority, R12 alignment)
    function automatic int exp_sel(logic vv, logic ww, logic pp, logic [23:0] aa);
        if (!vv || aa[0]) return 0;
        if (!pp && aa[23:4] == REG_BASE[23:4]) return 1;
        if (pp && !ww && m_boot && !m_stop && aa[23:3] == '0) return 2;
        if (!m_stop && aa[23:14] == m_base) return 3;
        return 0;
    endfunction

    function automatic logic [15:0] exp_data(int s, logic ww, logic [23:0] aa);
        if (ww) return '0;
        case (s)
            1: begin
                if (aa[3]) return BOOTW[aa[2:1]*16 +: 16];
                if (aa[3:1] == 3'd0) return {14'd0, m_boot, m_stop};
                if (aa[3:1] == 3'd1) return {6'd0, m_base};
                return '0;
            end
            2: return BOOTW[aa[2:1]*16 +: 16];
            3: return aa[16:1] ^ 16'h5A3C;
            default: return '0;
        endcase
    endfunction

    task automatic do_reset(logic ss, logic sb, logic pn);
        @(negedge clk);
        v = 0; rst_n = 0; sh_stop = ss; sh_boot = sb; pin = pn;
        repeat (2) @(negedge clk);
        chk("R10 ack low in reset", {31'd0, ack}, 0);
        rst_n = 1;
        m_stop = ss | ~pn; m_boot = sb; m_base = BASE_RST;
        // Flip shadows after reset: must have no effect (R1, R2)
        sh_stop = ~ss; sh_boot = ~sb; pin = ~pn;
        @(negedge clk);
        chk("R1 stop after reset", {31'd0, stop}, {31'd0, m_stop});
        chk("R2 boot after reset", {31'd0, boot}, {31'd0, m_boot});
    endtask

    task automatic xfer(logic vv, logic ww, logic pp, logic [23:0] aa, logic [15:0] dd, string tag);
        int s;
        logic [15:0] ed;
        v = vv; w = ww; p = pp; a = aa; wd = dd;
        s = exp_sel(vv, ww, pp, aa);
        ed = exp_data(s, ww, aa);
        @(posedge clk);
        if (s == 1 && ww && aa[3:1] == 3'd0) m_stop = dd[0];
        if (s == 1 && ww && aa[3:1] == 3'd1) m_base = dd[9:0];
        @(negedge clk);
        v = 0;
        chk({tag, " ack"}, {31'd0, ack}, {31'd0, s != 0});
        chk({tag, " data"}, {16'd0, rd}, {16'd0, ed});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // Erased part: stopped (R1), registers still reachable (R3)
        do_reset(1, 1, 1);
        xfer(1, 0, 1, 24'h000000, 0, "R3 boot while stopped");
        xfer(1, 0, 0, 24'h010020, 0, "R3 array while stopped");
        xfer(1, 0, 0, REG_BASE, 0, "R7 R2 ctrl read");
        xfer(1, 0, 0, REG_BASE | 24'h2, 0, "R11 base reset value");
        do_reset(0, 1, 0);
        do_reset(0, 1, 1);
        // Boot vectors in order (R4)
        for (int i = 0; i < 4; i++) xfer(1, 0, 1, 24'(2*i), 0, "R4 boot word");
        xfer(1, 0, 0, 24'h000002, 0, "R5 data-space boot address");
        xfer(1, 1, 1, 24'h000004, 16'h1234, "R5 boot write not claimed");
        xfer(1, 0, 1, 24'h000003, 0, "R12 odd address");
        xfer(1, 0, 0, 24'h010101, 0, "R12 odd array address");
        // Bootstrap word registers are read-only (R8)
        xfer(1, 1, 0, REG_BASE | 24'hA, 16'hFFFF, "R8 bootword write");
        xfer(1, 0, 0, REG_BASE | 24'hA, 0, "R8 bootword readback");
        // Array (R6)
        xfer(1, 0, 0, 24'h013ABC, 0, "R6 array read");
        xfer(1, 1, 1, 24'h012000, 16'h5555, "R6 array write");
        xfer(1, 0, 0, 24'h012000, 0, "R6 array after write");
        // Overlap: base 0 puts array over boot range (R9)
        xfer(1, 1, 0, REG_BASE | 24'h2, 16'h0000, "R7 base write");
        xfer(1, 0, 1, 24'h000002, 0, "R9 boot over array");
        xfer(1, 0, 0, 24'h000002, 0, "R9 array in data space");
        xfer(1, 1, 0, REG_BASE | 24'h2, {6'd0, BASE_RST}, "R7 base restore");
        // Stop through software (R3, R7)
        xfer(1, 1, 0, REG_BASE, 16'h0001, "R7 set stop");
        chk("R7 stop_o set", {31'd0, stop}, 1);
        xfer(1, 0, 0, 24'h010010, 0, "R3 array after stop");
        xfer(1, 1, 0, REG_BASE, 16'h0000, "R7 clear stop");
        xfer(1, 0, 0, 24'h010010, 0, "R6 array after clear");
        // Boot flag clear (R5)
        do_reset(0, 0, 1);
        xfer(1, 0, 1, 24'h000004, 0, "R5 boot disabled");
        xfer(1, 1, 0, REG_BASE, 16'h0003, "R2 write boot bit");
        chk("R2 boot unchanged", {31'd0, boot}, 0);
        do_reset(0, 1, 1);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [23:0] ra;
            logic rv, rw, rp;
            int k;
            k = $urandom % 5;
            case (k)
                0: ra = 24'($urandom % 8);
                1: ra = {m_base, 14'($urandom)};
                2: ra = REG_BASE | 24'($urandom % 16);
                3: ra = (($urandom % 8) == 0) ? REG_BASE | 24'($urandom % 4) : 24'($urandom);
                default: ra = 24'($urandom);
            endcase
            rv = ($urandom % 8) != 0;
            rw = ($urandom % 4) == 0;
            rp = $urandom % 2;
            if (k == 3) begin rp = 0; end
            xfer(rv, rw, rp, ra, 16'($urandom), "R10 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule